// File: doc/BRIEF.md
# Two-Wire Register Access Slave with Pointer Auto-Increment

This block is a slave on a two-wire open-drain serial bus. SC is the clock and SD is the data line, with the usual START, STOP, 8-bit byte and 9th-clock acknowledge framing. It gives a bus master access to 64 eight-bit registers. The master addresses the slave with a fixed 7-bit device address and a direction bit. In a write transfer, the next byte is a register address byte. That byte loads a 6-bit register pointer and an increment control flag.

The flag selects one of two modes. With the flag clear, the master alternates strictly between address bytes and data bytes, and the pointer is never advanced. With the flag set, writes step the pointer after each stored byte. Reads step the pointer before each byte is fetched, except for the first fetch after an address byte, which uses the loaded pointer as it is.

The slave only ever pulls SD low or releases it. Both bus lines are sampled through synchronisers on the system clock. A parallel side port lets the register contents be read without using the bus.

Top module: `ssr_slave`

## Requirements
- R1: After reset all 64 registers read 0 on the side port and SD is released (`sd_pull_o` = 0).
- R2: A byte whose upper seven bits differ from the device address (default 7'h3A) is not acknowledged. The rest of that transfer is ignored, so no register changes.
- R3: In a register address byte, bits 5:0 load the pointer and bit 6 is the increment flag (1 = increment). Bit 7 has no effect.
- R4: With the flag set, each written data byte is stored at the pointer and the pointer then advances by one, wrapping from 63 to 0.
- R5: With the flag clear, a written data byte leaves the pointer unchanged, and the next byte received is taken as a new register address byte.
- R6: With the flag set, the first byte read after an address byte comes from the loaded pointer. Every later byte fetch, including one in a later read transfer, first advances the pointer by one.
- R7: With the flag clear, reads never move the pointer, so every byte read returns the same register.
- R8: The slave acknowledges its device address and every written byte by holding SD low across the high phase of the 9th clock. It changes its SD drive only while SC is low.
- R9: When the master does not acknowledge a read byte, and after any STOP, the slave keeps SD released until the next START.
- R10: A START that arrives in the middle of a byte discards the partial byte and restarts framing with a device address byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| sc_i | input | 1 | Level of the serial clock line |
| sd_i | input | 1 | Resolved level of the serial data line |
| sd_pull_o | output | 1 | 1 pulls SD low, 0 releases it |
| side_addr_i | input | 6 | Register index for the side read port |
| side_data_o | output | 8 | Content of the register selected by `side_addr_i` |

## Verification
On the 9th falling SC edge of a read byte, two actions fall in the same cycle. The slave ends the acknowledge slot, and it also fetches the next register, which under the increment flag means advancing the pointer and driving the new byte's top bit. The bench provokes this with back-to-back acknowledged reads that cross the 63-to-0 wrap. A scoreboard fed from a reference pointer model compares every received byte. A second coincidence is a START landing mid-byte while bits are still being shifted; the bench judges it by reading both the abandoned and the newly addressed register through the side port.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
    localparam int unsigned AW    = 6;
    localparam int unsigned DW    = 8;
    localparam int unsigned DEPTH = 1 << AW;
    localparam int unsigned CW    = $clog2(DW + 2);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_RAB,
        PH_WDATA,
        PH_READ
    } phase_e;

    typedef struct packed {
        phase_e          phase;
        logic [CW-1:0]   cnt;
        logic [DW-1:0]   sh;
        logic            pull;
        logic [AW-1:0]   ptr;
        logic            inc;
        logic            first_rd;
        logic            mack;
    } ctl_s;
endpackage

// File: rtl/ssr_line_sync.sv
module ssr_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sc_i,
    input  logic sd_i,
    output logic sc_o,
    output logic sd_o,
    output logic sc_rise_o,
    output logic sc_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] sc_pipe_q, sd_pipe_q;
    logic              sc_prev_q, sd_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sc_pipe_q <= '1;
            sd_pipe_q <= '1;
            sc_prev_q <= 1'b1;
            sd_prev_q <= 1'b1;
        end else begin
            sc_pipe_q <= {sc_pipe_q[STAGES-2:0], sc_i};
            sd_pipe_q <= {sd_pipe_q[STAGES-2:0], sd_i};
            sc_prev_q <= sc_pipe_q[STAGES-1];
            sd_prev_q <= sd_pipe_q[STAGES-1];
        end
    end

    assign sc_o      = sc_pipe_q[STAGES-1];
    assign sd_o      = sd_pipe_q[STAGES-1];
    assign sc_rise_o = sc_o & ~sc_prev_q;
    assign sc_fall_o = ~sc_o & sc_prev_q;
    // data edges while the clock stays high are framing events
    assign start_o   = sc_o & sc_prev_q & sd_prev_q & ~sd_o;
    assign stop_o    = sc_o & sc_prev_q & ~sd_prev_q & sd_o;
endmodule

// File: rtl/ssr_reg_bank.sv
module ssr_reg_bank
    import ssr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_a_i,
    output logic [DW-1:0] rdata_a_o,
    input  logic [AW-1:0] raddr_b_i,
    output logic [DW-1:0] rdata_b_o
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_a_o = mem_q[raddr_a_i];
    assign rdata_b_o = mem_q[raddr_b_i];

    // R4: a strobed write lands at the addressed entry
    p_write_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/ssr_slave.sv
module ssr_slave
    import ssr_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR    = 7'h3A,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sc_i,
    input  logic          sd_i,
    output logic          sd_pull_o,
    input  logic [AW-1:0] side_addr_i,
    output logic [DW-1:0] side_data_o
);
    localparam logic [CW-1:0] BIT_LAST = CW'(DW);
    localparam logic [CW-1:0] ACK_SLOT = CW'(DW + 1);

    logic sc_s, sd_s, sc_rise, sc_fall, start_ev, stop_ev;
    ctl_s q, d;
    logic          we, ld_en;
    logic [AW-1:0] load_addr;
    logic [DW-1:0] rd_a;

    ssr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sc_i      (sc_i),
        .sd_i      (sd_i),
        .sc_o      (sc_s),
        .sd_o      (sd_s),
        .sc_rise_o (sc_rise),
        .sc_fall_o (sc_fall),
        .start_o   (start_ev),
        .stop_o    (stop_ev)
    );

    ssr_reg_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (we),
        .waddr_i   (q.ptr),
        .wdata_i   (q.sh),
        .raddr_a_i (load_addr),
        .rdata_a_o (rd_a),
        .raddr_b_i (side_addr_i),
        .rdata_b_o (side_data_o)
    );

    // first fetch after an address byte, or no increment: keep the pointer
    assign load_addr = (q.first_rd || !q.inc) ? q.ptr : q.ptr + AW'(1);

    always_comb begin
        d     = q;
        we    = 1'b0;
        ld_en = 1'b0;
        if (stop_ev) begin
            d.phase = PH_IDLE;
            d.pull  = 1'b0;
            d.cnt   = '0;
        end else if (start_ev) begin
            d.phase = PH_DEV;
            d.pull  = 1'b0;
            d.cnt   = '0;
        end else if (q.phase != PH_IDLE) begin
            if (sc_rise) begin
                if (q.cnt < BIT_LAST) begin
                    if (q.phase != PH_READ) d.sh = {q.sh[DW-2:0], sd_s};
                    d.cnt = q.cnt + CW'(1);
                end else if (q.cnt == BIT_LAST) begin
                    d.cnt = ACK_SLOT;
                    if (q.phase == PH_READ) d.mack = ~sd_s;
                end
            end else if (sc_fall) begin
                if (q.phase == PH_READ) begin
                    if (q.cnt >= CW'(1) && q.cnt < BIT_LAST) begin
                        d.sh   = {q.sh[DW-2:0], 1'b0};
                        d.pull = ~q.sh[DW-2];
                    end else if (q.cnt == BIT_LAST) begin
                        d.pull = 1'b0;
                    end else if (q.cnt == ACK_SLOT) begin
                        d.cnt = '0;
                        if (q.mack) begin
                            ld_en      = 1'b1;
                            d.ptr      = load_addr;
                            d.first_rd = 1'b0;
                            d.sh       = rd_a;
                            d.pull     = ~rd_a[DW-1];
                        end else begin
                            d.phase = PH_IDLE;
                            d.pull  = 1'b0;
                        end
                    end
                end else if (q.cnt == BIT_LAST) begin
                    unique case (q.phase)
                        PH_DEV: begin
                            if (q.sh[DW-1:1] == DEV_ADDR) begin
                                d.pull = 1'b1;
                                if (q.sh[0]) begin
                                    d.phase = PH_READ;
                                    d.mack  = 1'b1;
                                end else begin
                                    d.phase = PH_RAB;
                                end
                            end else begin
                                d.phase = PH_IDLE;
                            end
                        end
                        PH_RAB: begin
                            d.ptr      = q.sh[AW-1:0];
                            d.inc      = q.sh[AW];
                            d.first_rd = 1'b1;
                            d.pull     = 1'b1;
                            d.phase    = PH_WDATA;
                        end
                        PH_WDATA: begin
                            we     = 1'b1;
                            d.pull = 1'b1;
                            if (q.inc) d.ptr   = q.ptr + AW'(1);
                            else       d.phase = PH_RAB;
                        end
                        default: d.phase = PH_IDLE;
                    endcase
                end else if (q.cnt == ACK_SLOT) begin
                    d.pull = 1'b0;
                    d.cnt  = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, cnt: '0, sh: '0, pull: 1'b0, ptr: '0,
                   inc: 1'b0, first_rd: 1'b0, mack: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sd_pull_o = q.pull;

    // R8: drive on SD only moves while SC is low (framing events excepted)
    p_pull_quiet_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_s && $past(sc_s) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(q.pull));
    // R9: a STOP always leaves SD released
    p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !q.pull);
    // R10: START restarts framing on a device address byte
    p_restart_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev && !stop_ev) |=> (q.phase == PH_DEV && q.cnt == '0));
    // R4: incrementing write steps the pointer by one, modulo the bank size
    p_inc_write_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && q.inc) |=> q.ptr == AW'($past(q.ptr) + AW'(1)));
    // R5: alternating write keeps the pointer and expects an address byte
    p_alt_write_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !q.inc) |=> (q.ptr == $past(q.ptr) && q.phase == PH_RAB));
    // R6: later incrementing fetches pre-advance the pointer
    p_read_preinc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && q.inc && !q.first_rd) |=> q.ptr == AW'($past(q.ptr) + AW'(1)));
    // R7: non-incrementing fetches leave the pointer alone
    p_read_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !q.inc) |=> q.ptr == $past(q.ptr));
endmodule

// File: tb/test_ssr_slave.sv
`timescale 1ns/1ps
module test_ssr_slave;
    localparam logic [6:0] DEV = 7'h3A;
    localparam int Q = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sc_m = 1'b1;
    logic       sd_m = 1'b1;
    logic       sd_pull;
    logic       sd_bus;
    logic [5:0] side_addr = '0;
    logic [7:0] side_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_mem [64];
    logic [5:0] m_ptr = '0;
    logic       m_inc = 1'b0;
    logic       m_first = 1'b0;
    logic [7:0] exp_q [$];
    logic [7:0] got_byte;
    string      cur_req = "R6";
    event       got_ev;

    always #4 clk = ~clk;
    assign sd_bus = sd_m & ~sd_pull;

    ssr_slave #(.DEV_ADDR(DEV)) i_ssr_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .sc_i        (sc_m),
        .sd_i        (sd_bus),
        .sd_pull_o   (sd_pull),
        .side_addr_i (side_addr),
        .side_data_o (side_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sd_m = 1'b1; tick(Q); sc_m = 1'b1; tick(Q);
        sd_m = 1'b0; tick(Q); sc_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sd_m = 1'b0; tick(Q); sc_m = 1'b1; tick(Q); sd_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sd_m = b[i]; tick(Q); sc_m = 1'b1; tick(2*Q); sc_m = 1'b0; tick(Q);
        end
        sd_m = 1'b1; tick(Q); sc_m = 1'b1; tick(Q);
        ack = ~sd_bus;
        tick(Q); sc_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sd_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            tick(Q); sc_m = 1'b1; tick(Q);
            b = {b[6:0], sd_bus};
            tick(Q); sc_m = 1'b0;
        end
        tick(Q); sd_m = ~mack; tick(Q); sc_m = 1'b1; tick(2*Q); sc_m = 1'b0; tick(Q);
        sd_m = 1'b1;
    endtask

    task automatic side_chk(input string req, input logic [5:0] a, input logic [7:0] e);
        side_addr = a; tick(1);
        chk(req, side_data, e);
    endtask

    task automatic dev_phase(input logic rd, input logic exp_ack, input string req);
        logic ack;
        send_byte({DEV, rd}, ack);
        chk(req, ack, exp_ack);
    endtask

    task automatic rab(input logic [7:0] b);
        logic ack;
        send_byte(b, ack);
        chk("R8 address byte ack", ack, 1'b1);
        m_ptr = b[5:0]; m_inc = b[6]; m_first = 1'b1;
    endtask

    task automatic wdata(input logic [7:0] b);
        logic ack;
        send_byte(b, ack);
        chk("R8 data byte ack", ack, 1'b1);
        exp_mem[m_ptr] = b;
        if (m_inc) m_ptr = m_ptr + 6'd1;
    endtask

    task automatic read_bytes(input int n, input string req);
        logic [7:0] b;
        cur_req = req;
        for (int k = 0; k < n; k++) begin
            if (!m_first && m_inc) m_ptr = m_ptr + 6'd1;
            m_first = 1'b0;
            exp_q.push_back(exp_mem[m_ptr]);
            recv_byte(k < n - 1, b);
            got_byte = b;
            -> got_ev;
            tick(1);
        end
    endtask

    initial begin : monitor
        forever begin
            @(got_ev);
            if (exp_q.size() == 0) chk({cur_req, " unexpected byte"}, got_byte, 32'hDEAD);
            else chk(cur_req, got_byte, exp_q.pop_front());
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic ack;
        logic [7:0] b;
        bit all_zero;
        for (int i = 0; i < 64; i++) exp_mem[i] = '0;
        tick(5);
        // R1: reset state
        chk("R1 SD released in reset", sd_pull, 1'b0);
        rst_n = 1'b1; tick(5);
        all_zero = 1'b1;
        for (int i = 0; i < 64; i++) begin
            side_addr = 6'(i); tick(1);
            if (side_data !== 8'h00) all_zero = 1'b0;
        end
        chk("R1 registers zero after reset", all_zero, 1'b1);
        chk("R1 SD released after reset", sd_pull, 1'b0);

        // R2: foreign device address is ignored
        bus_start();
        send_byte({7'h15, 1'b0}, ack);
        chk("R2 foreign address not acked", ack, 1'b0);
        send_byte(8'h00, ack);
        chk("R2 following byte not acked", ack, 1'b0);
        send_byte(8'h99, ack);
        chk("R2 data not acked", ack, 1'b0);
        bus_stop();
        side_chk("R2 register untouched", 6'd0, 8'h00);

        // R3, R5: alternating writes, bit 7 of address byte ignored
        bus_start();
        dev_phase(1'b0, 1'b1, "R8 device address ack");
        rab(8'h85);
        wdata(8'h11);
        rab(8'h0A);
        wdata(8'h22);
        bus_stop();
        side_chk("R3 bit7 ignored, reg5 written", 6'd5, 8'h11);
        side_chk("R5 second address byte honoured", 6'd10, 8'h22);
        side_chk("R5 no increment into reg6", 6'd6, 8'h00);
        chk("R9 SD released after STOP", sd_pull, 1'b0);

        // R4: incrementing writes with wrap from 63 to 0
        bus_start();
        dev_phase(1'b0, 1'b1, "R8 device address ack");
        rab(8'h7E);
        wdata(8'hA0); wdata(8'hA1); wdata(8'hA2); wdata(8'hA3);
        bus_stop();
        side_chk("R4 reg62", 6'd62, 8'hA0);
        side_chk("R4 reg63", 6'd63, 8'hA1);
        side_chk("R4 wrap to reg0", 6'd0, 8'hA2);
        side_chk("R4 reg1", 6'd1, 8'hA3);

        // R6: incrementing reads across the wrap, then a later transfer
        bus_start();
        dev_phase(1'b0, 1'b1, "R8 device address ack");
        rab(8'h7E);
        bus_start();
        dev_phase(1'b1, 1'b1, "R8 read address ack");
        read_bytes(3, "R6 incrementing read");
        bus_stop();
        bus_start();
        dev_phase(1'b1, 1'b1, "R8 read address ack");
        read_bytes(2, "R6 later read pre-increments");
        bus_stop();

        // R7: non-incrementing reads repeat one register
        bus_start();
        dev_phase(1'b0, 1'b1, "R8 device address ack");
        rab(8'h05);
        bus_start();
        dev_phase(1'b1, 1'b1, "R8 read address ack");
        read_bytes(3, "R7 repeated read");
        // R9: after NACK the slave stays off the bus
        recv_byte(1'b0, b);
        chk("R9 released after NACK", b, 8'hFF);
        bus_stop();
        bus_start();
        dev_phase(1'b1, 1'b1, "R8 read address ack");
        read_bytes(1, "R7 pointer kept across transfers");
        bus_stop();

        // R10: repeated START in the middle of a data byte
        bus_start();
        dev_phase(1'b0, 1'b1, "R8 device address ack");
        rab(8'h03);
        for (int i = 7; i >= 4; i--) begin
            sd_m = b[i] ^ 1'b1; tick(Q); sc_m = 1'b1; tick(2*Q); sc_m = 1'b0; tick(Q);
        end
        bus_start();
        dev_phase(1'b0, 1'b1, "R10 address after restart acked");
        rab(8'h07);
        wdata(8'h77);
        bus_stop();
        side_chk("R10 partial byte discarded", 6'd3, 8'h00);
        side_chk("R10 new transfer written", 6'd7, 8'h77);
        chk("R6 scoreboard drained", exp_q.size(), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule